// File: doc/BRIEF.md
# Converter Result Byte Register with Read Lock

This block holds the latest result of an analog-to-digital converter and presents it to a processor as two byte-wide read-only registers: a low byte and a high byte. The result is `RES_W` bits wide, 10 by default, and `RES_W` must lie between 9 and 16. A conversion-complete strobe delivers each new value. The processor reads through a read strobe and a one-bit byte address. The read data is a combinational view of the stored value. An alignment control picks right or left placement of the result within the 16 bits that the two bytes form, and the view changes at once when that control changes.

A small lock state machine keeps the two bytes coherent. Reading the low byte freezes the visible value until the high byte is read. A result that arrives while the value is frozen is parked in a one-entry pending buffer, and a newer arrival replaces the parked one. The parked result is committed when the high byte is read. Reading only the high byte never locks, so software that needs only 8 bits of a left-aligned result can skip the low byte. Every commit of a new value raises a one-cycle pulse.

The state machine has three states. `ST_OPEN` means unlocked. `ST_LOCKED` means frozen with no result waiting. `ST_LOCKED_PEND` means frozen with a result parked. The transitions are:

- **lock**: a low read moves `ST_OPEN` to `ST_LOCKED`, or to `ST_LOCKED_PEND` when a conversion completes in the same cycle.
- **park**: a conversion moves `ST_LOCKED` to `ST_LOCKED_PEND`, and a conversion in `ST_LOCKED_PEND` replaces the parked result.
- **release**: a high read returns either locked state to `ST_OPEN`.
- **pass-through**: in `ST_OPEN`, a conversion commits directly and the state does not change.

Top module: `conv_result_port`

## Requirements
- R1: With `align_left`=0, `rd_addr`=0 selects the low byte, which shows result bits 7:0. `rd_addr`=1 selects the high byte, which shows result bits RES_W-1:8 in its lowest positions.
- R2: With `align_left`=1, the high byte shows result bits RES_W-1:RES_W-8. The low byte shows the remaining low result bits in its topmost positions.
- R3: A change of `align_left` changes `rd_data` in the same cycle, without waiting for a clock edge and regardless of conversion activity.
- R4: A read with `rd_en`=1 and `rd_addr`=0 locks the register. While it is locked, the visible value does not change until a read with `rd_addr`=1.
- R5: A conversion that completes while the register is locked is parked, and only the newest parked value is kept. A high-byte read commits the parked value, or commits a conversion completing in that same cycle, which takes precedence.
- R6: A high-byte read while the register is unlocked does not lock it. A later conversion then becomes visible on the next cycle.
- R7: After reset, both bytes read zero in either alignment, and the register is unlocked.
- R8: Bit positions that carry no result bit read as zero in both alignments.
- R9: `upd_pulse` is high for exactly the one cycle in which a newly committed value first appears on `rd_data`.
- R10: In the unlocked state, a conversion appears on `rd_data` in the cycle after `cv_done`. If a low-byte read happens in the same cycle as `cv_done`, the read locks first and the new result is parked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cv_done | input | 1 | One-cycle conversion-complete strobe |
| cv_value | input | RES_W | Result that accompanies `cv_done` |
| rd_en | input | 1 | Processor read strobe |
| rd_addr | input | 1 | Byte select: 0 for low, 1 for high |
| align_left | input | 1 | 0 for right alignment, 1 for left alignment |
| rd_data | output | 8 | Selected byte of the aligned result |
| upd_pulse | output | 1 | One-cycle pulse when a new value is committed |

## Verification
The bench builds the block with the default `RES_W` of 10. At that width the result splits into an 8-bit part and a 2-bit part, so each alignment puts the two spare bits at a different edge of a different byte, and both unused-bit rules are reachable. The directed phases drive conversions in the same cycle as low reads and as high reads, and send several conversions while the register is locked, which exercises every transition of the lock state machine. A random phase then mixes all the inputs against the behavioural model.

// File: rtl/crp_pkg.sv
package crp_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_OPEN        = 2'd0,
        ST_LOCKED      = 2'd1,
        ST_LOCKED_PEND = 2'd2
    } lock_state_t;

    typedef struct packed {
        logic commit_new;   // load visible value from incoming result
        logic commit_pend;  // load visible value from pending buffer
        logic park;         // load pending buffer from incoming result
    } lock_ctl_t;

endpackage

// File: rtl/crp_lock_fsm.sv
module crp_lock_fsm
    import crp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cv_done,
    input  logic        rd_lo,
    input  logic        rd_hi,
    output lock_state_t state_o,
    output lock_ctl_t   ctl_o
);

    lock_state_t state_q;
    lock_state_t state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OPEN;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPEN: begin
                if (rd_lo) begin
                    state_d = cv_done ? ST_LOCKED_PEND : ST_LOCKED;
                end
            end
            ST_LOCKED: begin
                if (rd_hi) begin
                    state_d = ST_OPEN;
                end else if (cv_done) begin
                    state_d = ST_LOCKED_PEND;
                end
            end
            ST_LOCKED_PEND: begin
                if (rd_hi) begin
                    state_d = ST_OPEN;
                end
            end
            default: state_d = ST_OPEN;
        endcase
    end

    // outputs
    always_comb begin
        ctl_o = '0;
        unique case (state_q)
            ST_OPEN: begin
                if (cv_done) begin
                    ctl_o.park       = rd_lo;
                    ctl_o.commit_new = !rd_lo;
                end
            end
            ST_LOCKED: begin
                if (cv_done) begin
                    ctl_o.commit_new = rd_hi;
                    ctl_o.park       = !rd_hi;
                end
            end
            ST_LOCKED_PEND: begin
                if (rd_hi) begin
                    ctl_o.commit_new  = cv_done;
                    ctl_o.commit_pend = !cv_done;
                end else begin
                    ctl_o.park = cv_done;
                end
            end
            default: ctl_o = '0;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/crp_result_hold.sv
module crp_result_hold
    import crp_pkg::*;
#(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [RES_W-1:0] cv_value,
    input  lock_ctl_t        ctl,
    output logic [RES_W-1:0] shown_o,
    output logic             upd_o
);

    logic [RES_W-1:0] shown_q;
    logic [RES_W-1:0] pend_q;
    logic             upd_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shown_q <= '0;
            pend_q  <= '0;
            upd_q   <= 1'b0;
        end else begin
            upd_q <= ctl.commit_new | ctl.commit_pend;
            if (ctl.commit_new) begin
                shown_q <= cv_value;
            end else if (ctl.commit_pend) begin
                shown_q <= pend_q;
            end
            if (ctl.park) begin
                pend_q <= cv_value;
            end
        end
    end

    assign shown_o = shown_q;
    assign upd_o   = upd_q;

endmodule

// File: rtl/crp_align_fmt.sv
module crp_align_fmt #(
    parameter int RES_W  = 10,
    parameter int BYTE_W = 8
) (
    input  logic [RES_W-1:0]  shown,
    input  logic              align_left,
    input  logic              sel_hi,
    output logic [BYTE_W-1:0] byte_o
);

    localparam int WORD_W = 2 * BYTE_W;
    localparam int PAD    = WORD_W - RES_W;

    logic [WORD_W-1:0] word_r;
    logic [WORD_W-1:0] word_l;
    logic [WORD_W-1:0] word_sel;

    assign word_r   = WORD_W'(shown);
    assign word_l   = word_r << PAD;
    assign word_sel = align_left ? word_l : word_r;
    assign byte_o   = sel_hi ? word_sel[WORD_W-1:BYTE_W] : word_sel[BYTE_W-1:0];

endmodule

// File: rtl/conv_result_port.sv
module conv_result_port
    import crp_pkg::*;
#(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cv_done,
    input  logic [RES_W-1:0] cv_value,
    input  logic             rd_en,
    input  logic             rd_addr,
    input  logic             align_left,
    output logic [7:0]       rd_data,
    output logic             upd_pulse
);

    logic             rd_lo;
    logic             rd_hi;
    lock_state_t      lk_state;
    lock_ctl_t        lk_ctl;
    logic [RES_W-1:0] shown;

    assign rd_lo = rd_en & ~rd_addr;
    assign rd_hi = rd_en & rd_addr;

    crp_lock_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .cv_done (cv_done),
        .rd_lo   (rd_lo),
        .rd_hi   (rd_hi),
        .state_o (lk_state),
        .ctl_o   (lk_ctl)
    );

    crp_result_hold #(.RES_W(RES_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .cv_value (cv_value),
        .ctl      (lk_ctl),
        .shown_o  (shown),
        .upd_o    (upd_pulse)
    );

    crp_align_fmt #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_fmt (
        .shown      (shown),
        .align_left (align_left),
        .sel_hi     (rd_addr),
        .byte_o     (rd_data)
    );

endmodule

// File: rtl/crp_checker.sv
module crp_checker
    import crp_pkg::*;
#(
    parameter int RES_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cv_done,
    input logic             rd_en,
    input logic             rd_addr,
    input logic             align_left,
    input logic [7:0]       rd_data,
    input logic             upd_pulse,
    input lock_state_t      lk_state,
    input logic [RES_W-1:0] shown
);

    localparam int PAD = 16 - RES_W;
    localparam logic [7:0] LO_PAD_MASK = 8'((1 << PAD) - 1);

    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_state != ST_OPEN) && !(rd_en && rd_addr) |=> !upd_pulse && $stable(shown)); // R4

    AST_HI_ONLY_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_state == ST_OPEN) && !(rd_en && !rd_addr) |=> lk_state == ST_OPEN); // R6

    AST_PARK_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_state == ST_LOCKED_PEND) && ($past(lk_state) != ST_LOCKED_PEND) |-> $past(cv_done)); // R5

    AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        upd_pulse |-> $past(cv_done) || $past(rd_en && rd_addr)); // R9

    AST_RIGHT_HI_PAD: assert property (@(posedge clk) disable iff (!rst_n)
        !align_left && rd_addr |-> (rd_data >> (RES_W - 8)) == 8'd0); // R8

    AST_LEFT_LO_PAD: assert property (@(posedge clk) disable iff (!rst_n)
        align_left && !rd_addr |-> (rd_data & LO_PAD_MASK) == 8'd0); // R8

endmodule

bind conv_result_port crp_checker #(.RES_W(RES_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cv_done    (cv_done),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .align_left (align_left),
    .rd_data    (rd_data),
    .upd_pulse  (upd_pulse),
    .lk_state   (lk_state),
    .shown      (shown)
);

// File: tb/sim_conv_result_port.sv
`timescale 1ns/1ps
module sim_conv_result_port;

    localparam int RES_W = 10;
    localparam int PAD   = 16 - RES_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cv_done = 1'b0;
    logic [RES_W-1:0] cv_value = '0;
    logic             rd_en = 1'b0;
    logic             rd_addr = 1'b0;
    logic             align_left = 1'b0;
    logic [7:0]       rd_data;
    logic             upd_pulse;

    int errors = 0;
    int checks = 0;

    // behavioural model
    int  m_vis = 0;
    int  m_pend = 0;
    bit  m_pend_ok = 0;
    bit  m_locked = 0;
    bit  m_upd = 0;

    always #2 clk = ~clk;

    conv_result_port #(.RES_W(RES_W)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .cv_done    (cv_done),
        .cv_value   (cv_value),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .align_left (align_left),
        .rd_data    (rd_data),
        .upd_pulse  (upd_pulse)
    );

    function automatic int expect_byte(int vis, bit left, bit hi);
        int word;
        word = left ? (vis << PAD) : vis;
        return hi ? ((word >> 8) & 255) : (word & 255);
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_update(bit done, int val, bit ren, bit addr);
        bit hi;
        bit lo;
        hi = ren && addr;
        lo = ren && !addr;
        m_upd = 0;
        if (!m_locked) begin
            if (lo) begin
                m_locked = 1;
                if (done) begin m_pend = val; m_pend_ok = 1; end
            end else if (done) begin
                m_vis = val; m_upd = 1;
            end
        end else begin
            if (hi) begin
                m_locked = 0;
                if (done) begin m_vis = val; m_upd = 1; end
                else if (m_pend_ok) begin m_vis = m_pend; m_upd = 1; end
                m_pend_ok = 0;
            end else if (done) begin
                m_pend = val; m_pend_ok = 1;
            end
        end
    endtask

    // one cycle: drive, compare combinational view, then clock the model
    task automatic step(bit done, int val, bit ren, bit addr, bit left, string tag);
        @(negedge clk);
        cv_done = done;
        cv_value = RES_W'(val);
        rd_en = ren;
        rd_addr = addr;
        align_left = left;
        #1;
        check({tag, " data"}, rd_data, expect_byte(m_vis, left, addr));
        check({tag, " upd"}, upd_pulse, m_upd);
        @(posedge clk);
        #0.5;
        model_update(done, val & ((1 << RES_W) - 1), ren, addr);
    endtask

    // the same stored value viewed through all four byte/alignment pairs
    task automatic view_all(string tag);
        for (int k = 0; k < 4; k++) step(0, 0, 0, k[0], k[1], tag);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R7: reset state, all views zero
        for (int k = 0; k < 4; k++) begin
            rd_addr = k[0]; align_left = k[1]; #1;
            check("R7 reset", rd_data, 0);
        end
        check("R7 upd", upd_pulse, 0);
        rst_n = 1'b1;

        // R10 / R9: direct commit while open
        step(1, 10'h2A5, 0, 0, 0, "R10 commit");
        step(0, 0, 0, 0, 0, "R9 pulse");
        // R1 / R2 / R8: all views of 0x2A5 and of all-ones
        view_all("R1 R2");
        step(1, 10'h3FF, 0, 0, 0, "R10 commit2");
        view_all("R8 pad");
        step(1, 10'h155, 0, 0, 1, "R2 commit");
        view_all("R1 R2b");

        // R3: toggle alignment on successive cycles
        for (int k = 0; k < 4; k++) step(0, 0, 0, 1, k[0], "R3 align");
        step(1, 10'h0C3, 0, 0, 1, "R3 during conv");

        // R4 / R5: low read locks, two conversions parked, newest kept
        step(0, 0, 1, 0, 0, "R4 lock");
        step(1, 10'h111, 0, 0, 0, "R5 park1");
        step(1, 10'h222, 1, 0, 1, "R5 park2");
        step(0, 0, 0, 1, 0, "R4 frozen");
        step(0, 0, 1, 1, 0, "R5 release");
        step(0, 0, 0, 0, 0, "R5 committed");
        view_all("R5 view");

        // R5: conversion in the same cycle as the high read wins
        step(0, 0, 1, 0, 0, "R4 lock2");
        step(1, 10'h0AA, 0, 0, 0, "R5 park3");
        step(1, 10'h301, 1, 1, 0, "R5 same cycle");
        step(0, 0, 0, 0, 0, "R5 newest");

        // R10: low read and conversion in the same cycle
        step(1, 10'h1E7, 1, 0, 0, "R10 lock+conv");
        step(0, 0, 0, 0, 0, "R10 held");
        step(0, 0, 1, 1, 0, "R10 release");
        step(0, 0, 0, 0, 0, "R10 visible");

        // R6: high-only reads never lock
        step(0, 0, 1, 1, 1, "R6 hi read");
        step(1, 10'h2F0, 1, 1, 1, "R6 hi+conv");
        step(1, 10'h10F, 0, 1, 1, "R6 next conv");
        step(0, 0, 1, 1, 1, "R6 visible");

        // mixed random traffic
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 3) == 0, int'($urandom % 1024), ($urandom % 2) == 1,
                 ($urandom % 2) == 1, ($urandom % 2) == 1, "R4 R5 random");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule